// File: doc/BRIEF.md
# Timed Multi-Channel Edge Scheduler

This block drives a group of digital output lines from short lists of timed transitions that a host refreshes once per calculation step. For every channel the host writes a list of entries. Each entry names a target level and an offset, in clock cycles, from the start of the step. A strobe marks each step boundary. On the strobe the block makes the freshly written lists live and restarts its step cycle counter. Each channel then walks its list in order and moves its line to the requested level once the counter reaches the entry's offset.

Storage is double-buffered, so the host always writes the lists for the next step while the current step plays out. Entries can be placeholders that leave the line alone. A line keeps its level until a later valid entry changes it, including across any number of step boundaries. Offsets that run backwards, and writes that exceed a channel's slot budget or the group-wide entry budget, are discarded and raise a sticky error flag.

Top module: `edge_sched`

## Requirements
- R1: After reset every output line is low and `order_err` is low.
- R2: If `step_start` is high at rising edge t, a valid entry with offset k at the head of a channel's list sets that line from rising edge t+k+1 onward. Code 2'b01 gives a high level and code 2'b00 gives a low level. No line changes at the edge that samples the strobe.
- R3: A channel applies its entries in the order they were written. A later entry takes effect only after the earlier one has been applied.
- R4: An entry whose code has bit 1 set (2'b11 is the "no transition" code), or whose offset is greater than or equal to `step_len`, is a placeholder. It leaves the line unchanged and does not raise `order_err`.
- R5: Entries written between two strobes run only in the step that the second strobe opens. An entry written in the same cycle as a strobe belongs to the step opened by the strobe after that.
- R6: Only channels with index below `n_active`, sampled at the strobe, respond to entries. The other lines keep their level.
- R7: A line keeps its level across step boundaries until a valid entry changes it.
- R8: An entry whose offset is lower than the last applied offset on its channel in the same step is skipped. It sets `order_err`, which stays high until reset.
- R9: Writes beyond a channel's configured slot count in one step are dropped and set `order_err`. The slot count is taken from parameter `CH_SLOTS`, 8 bits per channel with channel 0 in the lowest byte, and is limited to `SLOTS`.
- R10: Writes beyond `MAX_TOTAL` accepted entries across the group in one step are dropped and set `order_err`.
- R11: Channels run independently. Entries with the same offset on different channels change their lines at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_start | input | 1 | Step boundary strobe: swaps banks and restarts the cycle counter |
| step_len | input | OFF_W | Step length in cycles; offsets at or above it are placeholders |
| n_active | input | CH_W+1 | Number of enabled channels, starting from channel 0 |
| ld_valid | input | 1 | Write one entry into the shadow bank |
| ld_ch | input | CH_W | Channel of the entry being written |
| ld_code | input | 2 | Entry code: 00 low, 01 high, 1x no transition |
| ld_off | input | OFF_W | Entry offset in cycles from the step start |
| dout | output | NUM_CH | Output lines |
| order_err | output | 1 | Sticky error for out-of-order or over-budget entries |

## Verification
The collision that matters most is an entry write arriving in the same cycle as the step strobe. The bench provokes it by asserting both in a single cycle with a falling entry for a line that is currently high. It then requires that line to stay high for the whole of the step the strobe opens, and to fall at the expected edge of the following step. A second coincidence, two channels whose entries share an offset, is judged by requiring both lines to change at the same sampled cycle.

// File: rtl/edge_sched_pkg.sv
package edge_sched_pkg;

    // width of a step offset, in clock cycles
    localparam int unsigned OFF_W = 16;

    typedef logic [1:0] evt_code_t;

    localparam evt_code_t CODE_FALL = 2'b00;
    localparam evt_code_t CODE_RISE = 2'b01;
    localparam evt_code_t CODE_NONE = 2'b11;

    typedef struct packed {
        evt_code_t        code;
        logic [OFF_W-1:0] off;
    } evt_t;

    // bit 1 of the code marks an entry that requests no change
    function automatic logic code_is_hold(evt_code_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/edge_sched_loader.sv
module edge_sched_loader
    import edge_sched_pkg::*;
#(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned SLOTS     = 8,
    parameter int unsigned MAX_TOTAL = 250,
    parameter logic [NUM_CH*8-1:0] CH_SLOTS = {NUM_CH{8'd8}},
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned TOT_W = $clog2(MAX_TOTAL + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          ld_valid,
    input  logic [CH_W-1:0]               ld_ch,
    output logic                          wr_en,
    output logic [CNT_W-1:0]              wr_slot,
    output logic [NUM_CH-1:0][CNT_W-1:0]  sh_cnt,
    output logic [TOT_W-1:0]              total,
    output logic                          drop
);

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] cnt;
        logic [TOT_W-1:0]             total;
    } ld_st_t;

    ld_st_t st_d, st_q;

    // per-channel slot budget, never above the physical slot count
    function automatic logic [CNT_W-1:0] ch_limit(int c);
        int v;
        v = int'(CH_SLOTS[c*8 +: 8]);
        if (v > int'(SLOTS)) v = int'(SLOTS);
        return CNT_W'(v);
    endfunction

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_slot = '0;
        drop    = 1'b0;
        if (start) begin
            st_d.cnt   = '0;
            st_d.total = '0;
        end
        if (ld_valid) begin
            if (st_d.cnt[ld_ch] >= ch_limit(int'(ld_ch)) ||
                st_d.total >= TOT_W'(MAX_TOTAL)) begin
                drop = 1'b1;
            end else begin
                wr_en            = 1'b1;
                wr_slot          = st_d.cnt[ld_ch];
                st_d.cnt[ld_ch]  = st_d.cnt[ld_ch] + 1'b1;
                st_d.total       = st_d.total + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sh_cnt = st_q.cnt;
    assign total  = st_q.total;

endmodule

// File: rtl/edge_sched_store.sv
module edge_sched_store
    import edge_sched_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned SLOTS  = 8,
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned SL_W  = $clog2(SLOTS),
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic                          wr_bank,
    input  logic [CH_W-1:0]               wr_ch,
    input  logic [CNT_W-1:0]              wr_slot,
    input  evt_t                          wr_evt,
    input  logic                          rd_bank,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_idx,
    output evt_t [NUM_CH-1:0]             rd_evt
);

    // two banks: one live, one being filled
    evt_t mem_d [2][NUM_CH][SLOTS];
    evt_t mem_q [2][NUM_CH][SLOTS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_bank][wr_ch][wr_slot[SL_W-1:0]] = wr_evt;
    end

    // contents are qualified by the slot counts, so no reset is needed
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
        assign rd_evt[c] = mem_q[rd_bank][c][rd_idx[c][SL_W-1:0]];
    end

endmodule

// File: rtl/edge_sched_chan.sv
module edge_sched_chan
    import edge_sched_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              en_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [OFF_W-1:0]  step_len,
    input  logic [OFF_W-1:0]  cyc,
    input  evt_t              head,
    output logic [CNT_W-1:0]  idx,
    output logic              lvl,
    output logic              en,
    output logic              bad
);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [OFF_W-1:0] last;
        logic             lvl;
        logic             en;
    } ch_st_t;

    ch_st_t st_d, st_q;

    // one list entry is retired per cycle at most
    always_comb begin
        st_d = st_q;
        bad  = 1'b0;
        if (start) begin
            st_d.idx  = '0;
            st_d.cnt  = cnt_in;
            st_d.last = '0;
            st_d.en   = en_in;
        end else if (st_q.en && st_q.idx < st_q.cnt) begin
            if (code_is_hold(head.code) || head.off >= step_len) begin
                st_d.idx = st_q.idx + 1'b1;
            end else if (head.off < st_q.last) begin
                st_d.idx = st_q.idx + 1'b1;
                bad      = 1'b1;
            end else if (head.off <= cyc) begin
                st_d.lvl  = head.code[0];
                st_d.last = head.off;
                st_d.idx  = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
    assign lvl = st_q.lvl;
    assign en  = st_q.en;

endmodule

// File: rtl/edge_sched.sv
module edge_sched
    import edge_sched_pkg::*;
#(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned SLOTS     = 8,
    parameter int unsigned MAX_TOTAL = 250,
    parameter logic [NUM_CH*8-1:0] CH_SLOTS = {NUM_CH{8'd8}},
    localparam int unsigned CH_W  = $clog2(NUM_CH),
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned TOT_W = $clog2(MAX_TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_start,
    input  logic [OFF_W-1:0]  step_len,
    input  logic [CH_W:0]     n_active,
    input  logic              ld_valid,
    input  logic [CH_W-1:0]   ld_ch,
    input  logic [1:0]        ld_code,
    input  logic [OFF_W-1:0]  ld_off,
    output logic [NUM_CH-1:0] dout,
    output logic              order_err
);

    typedef struct packed {
        logic             bank;   // bank being played
        logic [OFF_W-1:0] cyc;    // cycles since the last strobe
        logic             err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                         wr_en;
    logic [CNT_W-1:0]             wr_slot;
    logic [NUM_CH-1:0][CNT_W-1:0] sh_cnt;
    logic [TOT_W-1:0]             ld_total;
    logic                         ld_drop;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_idx;
    evt_t [NUM_CH-1:0]            rd_evt;
    logic [NUM_CH-1:0]            chan_bad;
    logic [NUM_CH-1:0]            en_mask;
    logic                         wr_bank;
    evt_t                         wr_evt;

    always_comb begin
        st_d = st_q;
        if (step_start) begin
            st_d.bank = ~st_q.bank;
            st_d.cyc  = '0;
        end else if (st_q.cyc != {OFF_W{1'b1}}) begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
        if (ld_drop || (|chan_bad)) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a write in the strobe cycle lands in the bank that becomes shadow
    assign wr_bank = step_start ? st_q.bank : ~st_q.bank;
    assign wr_evt  = '{code: ld_code, off: ld_off};

    edge_sched_loader #(
        .NUM_CH(NUM_CH), .SLOTS(SLOTS), .MAX_TOTAL(MAX_TOTAL), .CH_SLOTS(CH_SLOTS)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .start(step_start),
        .ld_valid(ld_valid), .ld_ch(ld_ch),
        .wr_en(wr_en), .wr_slot(wr_slot), .sh_cnt(sh_cnt),
        .total(ld_total), .drop(ld_drop)
    );

    edge_sched_store #(
        .NUM_CH(NUM_CH), .SLOTS(SLOTS)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_ch(ld_ch),
        .wr_slot(wr_slot), .wr_evt(wr_evt),
        .rd_bank(st_q.bank), .rd_idx(rd_idx), .rd_evt(rd_evt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        edge_sched_chan #(
            .SLOTS(SLOTS)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .start(step_start),
            .en_in((CH_W+1)'(c) < n_active),
            .cnt_in(sh_cnt[c]), .step_len(step_len), .cyc(st_q.cyc),
            .head(rd_evt[c]), .idx(rd_idx[c]), .lvl(dout[c]),
            .en(en_mask[c]), .bad(chan_bad[c])
        );
    end

    assign order_err = st_q.err;

endmodule

// File: rtl/edge_sched_chk.sv
module edge_sched_chk #(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned SLOTS     = 8,
    parameter int unsigned MAX_TOTAL = 250,
    parameter logic [NUM_CH*8-1:0] CH_SLOTS = {NUM_CH{8'd8}},
    localparam int unsigned CNT_W = $clog2(SLOTS + 1),
    localparam int unsigned TOT_W = $clog2(MAX_TOTAL + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         step_start,
    input logic [NUM_CH-1:0]            dout,
    input logic                         order_err,
    input logic [NUM_CH-1:0]            en_mask,
    input logic [TOT_W-1:0]             total,
    input logic [NUM_CH-1:0][CNT_W-1:0] sh_cnt
);

    // R2: the edge that samples the strobe changes no line
    p_strobe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_start |=> (dout == $past(dout)));

    // R6: lines of channels not enabled never move
    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((dout ^ $past(dout)) & ~$past(en_mask)) == '0));

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> order_err);

    // R10: accepted entries never exceed the group budget
    p_total_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        total <= TOT_W'(MAX_TOTAL));

    // R9: each shadow list stays within its slot budget
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
        localparam int unsigned RAW = int'(CH_SLOTS[c*8 +: 8]);
        localparam int unsigned LIM = (RAW > SLOTS) ? SLOTS : RAW;
        p_slot_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sh_cnt[c] <= CNT_W'(LIM));
    end

endmodule

bind edge_sched edge_sched_chk #(
    .NUM_CH(NUM_CH), .SLOTS(SLOTS), .MAX_TOTAL(MAX_TOTAL), .CH_SLOTS(CH_SLOTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .step_start(step_start), .dout(dout),
    .order_err(order_err), .en_mask(en_mask), .total(ld_total), .sh_cnt(sh_cnt)
);

// File: tb/edge_sched_tb.sv
module edge_sched_tb;
    import edge_sched_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step_start = 1'b0;
    logic [OFF_W-1:0] step_len = 16'd40;
    logic [3:0]      n_active = 4'd4;
    logic            ld_valid = 1'b0;
    logic [2:0]      ld_ch = '0;
    logic [1:0]      ld_code = '0;
    logic [OFF_W-1:0] ld_off = '0;
    logic [NCH-1:0]  dout;
    logic            order_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_sched #(
        .NUM_CH(NCH), .SLOTS(8), .MAX_TOTAL(24),
        .CH_SLOTS({8'd8, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8, 8'd3, 8'd8})
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .step_start(step_start), .step_len(step_len),
        .n_active(n_active), .ld_valid(ld_valid), .ld_ch(ld_ch),
        .ld_code(ld_code), .ld_off(ld_off), .dout(dout), .order_err(order_err)
    );

    int unsigned cyc_cnt = 0;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        int unsigned cyc;
        int          ch;
        logic        val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_cnt);
        end
    endtask

    // driver side: queue an expected line level at a bench cycle
    task automatic expect_bit(input int unsigned c, input int ch, input logic v, input string tag);
        exp_t it;
        int pos;
        it.cyc = c; it.ch = ch; it.val = v; it.tag = tag;
        pos = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i].cyc > c) begin
                pos = i;
                break;
            end
        end
        exp_q.insert(pos, it);
    endtask

    // monitor side: compare each item in its cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc_cnt) begin
            exp_t it;
            it = exp_q.pop_front();
            if (it.cyc < cyc_cnt)
                check(1'b0, {it.tag, " missed sample"}, 0, 1);
            else
                check(dout[it.ch] === it.val, $sformatf("%s ch%0d", it.tag, it.ch),
                      int'(dout[it.ch]), int'(it.val));
        end
    end

    task automatic load(input int ch, input logic [1:0] code, input int off);
        ld_valid = 1'b1; ld_ch = 3'(ch); ld_code = code; ld_off = OFF_W'(off);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic strobe(output int unsigned s);
        s = cyc_cnt;
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
    endtask

    task automatic strobe_load(output int unsigned s, input int ch, input logic [1:0] code, input int off);
        s = cyc_cnt;
        step_start = 1'b1;
        ld_valid = 1'b1; ld_ch = 3'(ch); ld_code = code; ld_off = OFF_W'(off);
        @(negedge clk);
        step_start = 1'b0;
        ld_valid = 1'b0;
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc_cnt < c) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned s1, s2, s3, s4, s5;
        @(negedge clk);
        do_reset();
        check(dout == '0, "R1 dout after reset", int'(dout), 0);
        check(order_err == 1'b0, "R1 err after reset", int'(order_err), 0);

        // lists for step A
        load(0, CODE_RISE, 2);
        load(0, CODE_FALL, 6);
        load(2, CODE_RISE, 4);
        load(3, CODE_RISE, 4);
        load(5, CODE_RISE, 1);
        load(1, CODE_NONE, 3);
        load(1, CODE_RISE, 40);
        strobe(s1);
        expect_bit(s1+3, 0, 1'b0, "R2 before offset");
        expect_bit(s1+4, 0, 1'b1, "R2 rise at offset");
        expect_bit(s1+7, 0, 1'b1, "R3 first entry held");
        expect_bit(s1+8, 0, 1'b0, "R3 second entry");
        expect_bit(s1+5, 2, 1'b0, "R11 before");
        expect_bit(s1+5, 3, 1'b0, "R11 before");
        expect_bit(s1+6, 2, 1'b1, "R11 same edge");
        expect_bit(s1+6, 3, 1'b1, "R11 same edge");
        expect_bit(s1+45, 1, 1'b0, "R4 placeholders");
        expect_bit(s1+45, 5, 1'b0, "R6 disabled channel");
        expect_bit(s1+45, 0, 1'b0, "R5 next-step entry not early");

        // lists for step B, written while A plays
        load(0, CODE_RISE, 10);
        load(2, CODE_FALL, 20);
        load(2, CODE_RISE, 8);
        wait_until(s1+45);
        check(order_err == 1'b0, "R4 no error from placeholders", int'(order_err), 0);
        wait_until(s1+50);
        strobe_load(s2, 3, CODE_FALL, 5);
        expect_bit(s2+11, 0, 1'b0, "R5 before offset");
        expect_bit(s2+12, 0, 1'b1, "R5 runs in next step");
        expect_bit(s2+20, 2, 1'b1, "R7 held across boundary");
        expect_bit(s2+21, 2, 1'b1, "R3 before fall");
        expect_bit(s2+22, 2, 1'b0, "R3 fall");
        expect_bit(s2+45, 2, 1'b0, "R8 backward entry skipped");
        expect_bit(s2+45, 3, 1'b1, "R5 strobe-cycle write deferred");

        load(0, CODE_FALL, 0);
        wait_until(s2+45);
        check(order_err == 1'b1, "R8 error raised", int'(order_err), 1);
        wait_until(s2+50);
        strobe(s3);
        expect_bit(s3+1, 0, 1'b1, "R2 strobe edge quiet");
        expect_bit(s3+2, 0, 1'b0, "R2 offset zero");
        expect_bit(s3+6, 3, 1'b1, "R5 collision before");
        expect_bit(s3+7, 3, 1'b0, "R5 collision entry");
        wait_until(s3+45);
        check(order_err == 1'b1, "R8 error sticky", int'(order_err), 1);

        // slot budget on channel 1 (3 slots)
        do_reset();
        check(dout == '0, "R1 dout after second reset", int'(dout), 0);
        load(1, CODE_RISE, 1);
        load(1, CODE_FALL, 2);
        load(1, CODE_RISE, 3);
        check(order_err == 1'b0, "R9 within budget", int'(order_err), 0);
        load(1, CODE_FALL, 4);
        check(order_err == 1'b1, "R9 over budget", int'(order_err), 1);
        strobe(s4);
        expect_bit(s4+3, 1, 1'b1, "R9 kept entry 1");
        expect_bit(s4+4, 1, 1'b0, "R9 kept entry 2");
        expect_bit(s4+5, 1, 1'b1, "R9 kept entry 3");
        expect_bit(s4+7, 1, 1'b1, "R9 dropped entry absent");
        wait_until(s4+20);

        // group budget of 24 entries
        do_reset();
        for (int ch = 4; ch < 7; ch++)
            for (int k = 0; k < 8; k++) load(ch, CODE_NONE, 0);
        check(order_err == 1'b0, "R10 at budget", int'(order_err), 0);
        load(0, CODE_RISE, 3);
        check(order_err == 1'b1, "R10 over budget", int'(order_err), 1);
        strobe(s5);
        expect_bit(s5+10, 0, 1'b0, "R10 dropped entry absent");
        wait_until(s5+20);

        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule